// File: doc/BRIEF.md
# Serial Controller Interrupt Prioritiser and Identifier

This block gathers the four interrupt causes of a serial controller, masks them with a 4-bit enable value, picks the most urgent one by a fixed priority and reports it as an 8-bit identification code and a single active-high request line. It also holds the latched status flags behind those causes: the line status flags, the modem delta flags and the transmit-empty pending flag. Each flag is cleared by the host access that normally services it.

The host side presents single-cycle read and write strobes together with decoded register selects. The serial side presents single-cycle set pulses: a received byte, parity, framing and break errors, the transmit holding register becoming empty, and modem line deltas. When a set pulse and a clearing access hit the same flag in the same cycle, the set wins, so no event is lost.

The reported source is held in a state register with five named states. `SRC_NONE` reports no interrupt. `SRC_LINE` reports a line status error, `SRC_DATA` received data, `SRC_TXE` holding register empty and `SRC_MODEM` a modem change. On every clock edge the state moves to the highest-priority enabled pending source, or to `SRC_NONE` if none is pending. Any state can move to any other state on any edge.

Top module: `uart_irq_ident`

## Requirements
- R1: After a synchronous reset the line status value is 0x60 (bit 5 holding-empty, bit 6 transmitter-empty), the modem deltas are 0, and the transmit-empty interrupt is pending. Data ready is bit 0 and the error flags are parity bit 2, framing bit 3 and break bit 4.
- R2: Enable bit 0 gates received data, bit 1 gates transmit-empty, bit 2 gates line status errors, and bit 3 gates modem deltas.
- R3: With no enabled source pending, the identification code is 0x01 and `irq` is low. Otherwise `irq` is high.
- R4: The codes are 0x06 for a line error, 0x04 for received data, 0x02 for transmit-empty and 0x00 for a modem change. Priority runs in that order, highest first.
- R5: The identification code and `irq` follow a change of the enable value or of the pending flags at the next clock edge.
- R6: A line status read clears the parity, framing and break flags and so the line interrupt. Data ready and the transmitter bits are kept.
- R7: A receive buffer read clears data ready and the received-data interrupt.
- R8: A modem status read clears all delta flags and the modem interrupt.
- R9: A holding register write clears the transmit-empty interrupt and line status bits 5 and 6. A later empty pulse sets them again.
- R10: An identification read while the code being reported is 0x02 clears the transmit-empty interrupt. The same read while another code is reported leaves it pending.
- R11: A set pulse that coincides with a clearing access leaves its flag set.
- R12: Bits 7:4 of the identification code are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ier | input | 4 | Interrupt enable value |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wr | input | 1 | Host write strobe, one cycle |
| sel_lsr | input | 1 | Line status register selected |
| sel_rbr | input | 1 | Receive buffer selected (read) |
| sel_thr | input | 1 | Transmit holding register selected (write) |
| sel_msr | input | 1 | Modem status register selected |
| sel_iir | input | 1 | Identification register selected |
| rx_byte_set | input | 1 | A received byte has arrived |
| rx_err_set | input | 3 | Error pulses: bit 0 parity, bit 1 framing, bit 2 break |
| tx_empty_set | input | 1 | Holding register has just emptied |
| modem_delta_set | input | 4 | Modem line change pulses |
| irq | output | 1 | Interrupt request, active high |
| iir_val | output | 8 | Identification code |
| lsr_val | output | 8 | Line status value |
| modem_delta | output | 4 | Latched modem delta flags |

## Verification
The assertions assume that the set and access inputs are single-cycle pulses. They also assume that at most one register select is asserted with a strobe. The clearing properties assume that no set pulse for the same flag coincides with the clearing access, and they state that exclusion in their antecedents. The bench drives each access as one strobe with one select for a single cycle. Its sweep sets up every enable value against every pending pattern, using only set pulses and clearing writes spaced by idle cycles.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int unsigned SRC_N    = 4;
    localparam int unsigned ERR_W    = 3;
    localparam int unsigned DELTA_W  = 4;
    localparam int unsigned CODE_W   = 8;

    // bit positions inside the enable / pending vectors
    localparam int unsigned BIT_DATA  = 0;
    localparam int unsigned BIT_TXE   = 1;
    localparam int unsigned BIT_LINE  = 2;
    localparam int unsigned BIT_MODEM = 3;

    localparam logic [CODE_W-1:0] CODE_NONE  = 8'h01;
    localparam logic [CODE_W-1:0] CODE_LINE  = 8'h06;
    localparam logic [CODE_W-1:0] CODE_DATA  = 8'h04;
    localparam logic [CODE_W-1:0] CODE_TXE   = 8'h02;
    localparam logic [CODE_W-1:0] CODE_MODEM = 8'h00;

    typedef enum logic [2:0] {
        SRC_NONE  = 3'd0,
        SRC_LINE  = 3'd1,
        SRC_DATA  = 3'd2,
        SRC_TXE   = 3'd3,
        SRC_MODEM = 3'd4
    } src_e;
endpackage

// File: rtl/uart_irq_lsr.sv
module uart_irq_lsr
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             lsr_rd,
    input  logic             rbr_rd,
    input  logic             thr_wr,
    input  logic             txe_ack,
    input  logic             rx_byte_set,
    input  logic [ERR_W-1:0] rx_err_set,
    input  logic             tx_empty_set,
    output logic [7:0]       lsr_val,
    output logic             data_pend,
    output logic             line_pend,
    output logic             txe_pend
);
    logic             dr_q;
    logic [ERR_W-1:0] err_q;
    logic             thre_q;
    logic             txe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dr_q   <= 1'b0;
            err_q  <= '0;
            thre_q <= 1'b1;
            txe_q  <= 1'b1;
        end else begin
            if (rx_byte_set)      dr_q <= 1'b1;
            else if (rbr_rd)      dr_q <= 1'b0;

            for (int i = 0; i < ERR_W; i++) begin
                if (rx_err_set[i]) err_q[i] <= 1'b1;
                else if (lsr_rd)   err_q[i] <= 1'b0;
            end

            if (tx_empty_set)     thre_q <= 1'b1;
            else if (thr_wr)      thre_q <= 1'b0;

            if (tx_empty_set)              txe_q <= 1'b1;
            else if (thr_wr || txe_ack)    txe_q <= 1'b0;
        end
    end

    always_comb begin
        lsr_val      = '0;
        lsr_val[0]   = dr_q;
        lsr_val[4:2] = err_q;
        lsr_val[5]   = thre_q;
        lsr_val[6]   = thre_q;
    end

    assign data_pend = dr_q;
    assign line_pend = |err_q;
    assign txe_pend  = txe_q;

    p_lsr_rd_clr_r6: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd && rx_err_set == '0) |=> (lsr_val[4:2] == '0));
    p_rbr_rd_clr_r7: assert property (@(posedge clk) disable iff (rst)
        (rbr_rd && !rx_byte_set) |=> !data_pend);
    p_thr_wr_clr_r9: assert property (@(posedge clk) disable iff (rst)
        (thr_wr && !tx_empty_set) |=> (!txe_pend && !lsr_val[5]));
    p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
        rx_byte_set |=> data_pend);
endmodule

// File: rtl/uart_irq_mdelta.sv
module uart_irq_mdelta
    import uart_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               msr_rd,
    input  logic [DELTA_W-1:0] delta_set,
    output logic [DELTA_W-1:0] delta_q,
    output logic               modem_pend
);
    for (genvar g = 0; g < DELTA_W; g++) begin : g_delta
        always_ff @(posedge clk) begin
            if (rst)               delta_q[g] <= 1'b0;
            else if (delta_set[g]) delta_q[g] <= 1'b1;
            else if (msr_rd)       delta_q[g] <= 1'b0;
        end
    end

    assign modem_pend = |delta_q;

    p_msr_rd_clr_r8: assert property (@(posedge clk) disable iff (rst)
        (msr_rd && delta_set == '0) |=> (delta_q == '0));
endmodule

// File: rtl/uart_irq_fsm.sv
module uart_irq_fsm
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_N-1:0]  pend,
    input  logic [SRC_N-1:0]  ier,
    output src_e              state,
    output logic              irq,
    output logic [CODE_W-1:0] code
);
    logic [SRC_N-1:0] live;
    src_e             state_nx;

    assign live = pend & ier;

    always_comb begin
        if (live[BIT_LINE])       state_nx = SRC_LINE;
        else if (live[BIT_DATA])  state_nx = SRC_DATA;
        else if (live[BIT_TXE])   state_nx = SRC_TXE;
        else if (live[BIT_MODEM]) state_nx = SRC_MODEM;
        else                      state_nx = SRC_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SRC_NONE;
        else     state <= state_nx;
    end

    always_comb begin
        irq  = 1'b0;
        code = CODE_NONE;
        unique case (state)
            SRC_NONE:  begin irq = 1'b0; code = CODE_NONE;  end
            SRC_LINE:  begin irq = 1'b1; code = CODE_LINE;  end
            SRC_DATA:  begin irq = 1'b1; code = CODE_DATA;  end
            SRC_TXE:   begin irq = 1'b1; code = CODE_TXE;   end
            SRC_MODEM: begin irq = 1'b1; code = CODE_MODEM; end
            default:   begin irq = 1'b0; code = CODE_NONE;  end
        endcase
    end

    p_line_first_r4: assert property (@(posedge clk) disable iff (rst)
        live[BIT_LINE] |=> (code == CODE_LINE));
    p_idle_low_r3: assert property (@(posedge clk) disable iff (rst)
        (live == '0) |=> (!irq && code == CODE_NONE));
    p_any_high_r5: assert property (@(posedge clk) disable iff (rst)
        (live != '0) |=> irq);
    p_upper_zero_r12: assert property (@(posedge clk) disable iff (rst)
        code[7:4] == 4'h0);
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic [3:0]   ier,
    input  logic         host_rd,
    input  logic         host_wr,
    input  logic         sel_lsr,
    input  logic         sel_rbr,
    input  logic         sel_thr,
    input  logic         sel_msr,
    input  logic         sel_iir,
    input  logic         rx_byte_set,
    input  logic [2:0]   rx_err_set,
    input  logic         tx_empty_set,
    input  logic [3:0]   modem_delta_set,
    output logic         irq,
    output logic [7:0]   iir_val,
    output logic [7:0]   lsr_val,
    output logic [3:0]   modem_delta
);
    src_e             state;
    logic [SRC_N-1:0] pend;
    logic             data_pend, line_pend, txe_pend, modem_pend;
    logic             txe_ack;

    // identification read while transmit-empty is the reported code
    assign txe_ack = host_rd && sel_iir && (state == SRC_TXE);

    uart_irq_lsr u_lsr (
        .clk          (clk),
        .rst          (rst),
        .lsr_rd       (host_rd && sel_lsr),
        .rbr_rd       (host_rd && sel_rbr),
        .thr_wr       (host_wr && sel_thr),
        .txe_ack      (txe_ack),
        .rx_byte_set  (rx_byte_set),
        .rx_err_set   (rx_err_set),
        .tx_empty_set (tx_empty_set),
        .lsr_val      (lsr_val),
        .data_pend    (data_pend),
        .line_pend    (line_pend),
        .txe_pend     (txe_pend)
    );

    uart_irq_mdelta u_mdelta (
        .clk        (clk),
        .rst        (rst),
        .msr_rd     (host_rd && sel_msr),
        .delta_set  (modem_delta_set),
        .delta_q    (modem_delta),
        .modem_pend (modem_pend)
    );

    always_comb begin
        pend            = '0;
        pend[BIT_DATA]  = data_pend;
        pend[BIT_TXE]   = txe_pend;
        pend[BIT_LINE]  = line_pend;
        pend[BIT_MODEM] = modem_pend;
    end

    uart_irq_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .pend  (pend),
        .ier   (ier),
        .state (state),
        .irq   (irq),
        .code  (iir_val)
    );

    p_iir_ack_r10: assert property (@(posedge clk) disable iff (rst)
        (txe_ack && !tx_empty_set) |=> !txe_pend);
    p_irq_code_r3: assert property (@(posedge clk) disable iff (rst)
        irq == (iir_val != CODE_NONE));
endmodule

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ier = 4'h0;
    logic       host_rd = 1'b0, host_wr = 1'b0;
    logic       sel_lsr = 1'b0, sel_rbr = 1'b0, sel_thr = 1'b0, sel_msr = 1'b0, sel_iir = 1'b0;
    logic       rx_byte_set = 1'b0;
    logic [2:0] rx_err_set = 3'b0;
    logic       tx_empty_set = 1'b0;
    logic [3:0] modem_delta_set = 4'b0;
    logic       irq;
    logic [7:0] iir_val, lsr_val;
    logic [3:0] modem_delta;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    uart_irq_ident dut_i (
        .clk(clk), .rst(rst), .ier(ier), .host_rd(host_rd), .host_wr(host_wr),
        .sel_lsr(sel_lsr), .sel_rbr(sel_rbr), .sel_thr(sel_thr), .sel_msr(sel_msr),
        .sel_iir(sel_iir), .rx_byte_set(rx_byte_set), .rx_err_set(rx_err_set),
        .tx_empty_set(tx_empty_set), .modem_delta_set(modem_delta_set),
        .irq(irq), .iir_val(iir_val), .lsr_val(lsr_val), .modem_delta(modem_delta)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_code(input logic [3:0] m);
        if (m[2])      return 8'h06;
        else if (m[0]) return 8'h04;
        else if (m[1]) return 8'h02;
        else if (m[3]) return 8'h00;
        else           return 8'h01;
    endfunction

    task automatic do_reset();
        rst = 1'b1; tick(); rst = 1'b0;
    endtask
    task automatic rd_acc(input int which); // 0 lsr 1 rbr 2 msr 3 iir
        host_rd = 1'b1;
        sel_lsr = (which == 0); sel_rbr = (which == 1);
        sel_msr = (which == 2); sel_iir = (which == 3);
        tick();
        host_rd = 1'b0; sel_lsr = 1'b0; sel_rbr = 1'b0; sel_msr = 1'b0; sel_iir = 1'b0;
    endtask
    task automatic thr_write();
        host_wr = 1'b1; sel_thr = 1'b1; tick(); host_wr = 1'b0; sel_thr = 1'b0;
    endtask
    task automatic pulse_byte();
        rx_byte_set = 1'b1; tick(); rx_byte_set = 1'b0;
    endtask
    task automatic pulse_err(input logic [2:0] e);
        rx_err_set = e; tick(); rx_err_set = 3'b0;
    endtask
    task automatic pulse_delta(input logic [3:0] d);
        modem_delta_set = d; tick(); modem_delta_set = 4'b0;
    endtask
    task automatic pulse_empty();
        tx_empty_set = 1'b1; tick(); tx_empty_set = 1'b0;
    endtask

    initial begin
        #1;
        tick(2);
        do_reset();
        tick();
        // R1 reset state
        chk("R1 lsr after reset", lsr_val, 8'h60);
        chk("R1 modem deltas after reset", {4'h0, modem_delta}, 8'h00);
        chk("R3 code with enables off", iir_val, 8'h01);
        chk("R3 irq with enables off", {7'b0, irq}, 8'h00);
        ier = 4'h2; tick();
        chk("R1 transmit-empty pending after reset", iir_val, 8'h02);

        // R2 R4 R12 sweep: every enable value against every pending pattern
        for (int p = 0; p < 16; p++) begin
            for (int e = 0; e < 16; e++) begin
                ier = 4'h0;
                do_reset();
                if (!p[1]) thr_write();
                if (p[0]) pulse_byte();
                if (p[2]) pulse_err(3'b001 << (e % 3));
                if (p[3]) pulse_delta(4'b0001 << (e % 4));
                ier = e[3:0];
                tick(2);
                chk($sformatf("R4 code ier=%h pend=%h", e, p), iir_val, exp_code(e[3:0] & p[3:0]));
                chk($sformatf("R3 irq ier=%h pend=%h", e, p), {7'b0, irq},
                    {7'b0, ((e[3:0] & p[3:0]) != 4'h0)});
                chk($sformatf("R12 upper bits ier=%h pend=%h", e, p), {4'h0, iir_val[7:4]}, 8'h00);
            end
        end

        // R4 ordered exposure with everything pending
        ier = 4'h0; do_reset();
        pulse_byte(); pulse_err(3'b111); pulse_delta(4'hF);
        chk("R1 lsr with all errors and data", lsr_val, 8'h7D);
        ier = 4'hF; tick();
        chk("R4 all enabled reports line", iir_val, 8'h06);
        ier = 4'hB; tick();
        chk("R4 line disabled reports data", iir_val, 8'h04);
        ier = 4'hA; tick();
        chk("R4 data disabled reports transmit-empty", iir_val, 8'h02);
        ier = 4'h8; tick();
        chk("R4 only modem left", iir_val, 8'h00);

        // R5 one-edge latency of an enable change
        ier = 4'h0; tick();
        chk("R5 zero enable drops irq", {7'b0, irq}, 8'h00);
        ier = 4'h4;
        #2;
        chk("R5 irq before the edge", {7'b0, irq}, 8'h00);
        tick();
        chk("R5 irq after one edge", {7'b0, irq}, 8'h01);

        // R6 line status read
        rd_acc(0); tick();
        chk("R6 errors cleared, data ready kept", lsr_val, 8'h61);
        chk("R6 line irq gone", {7'b0, irq}, 8'h00);

        // R7 receive buffer read
        ier = 4'h1; tick();
        chk("R7 data reported", iir_val, 8'h04);
        rd_acc(1); tick();
        chk("R7 data ready cleared", lsr_val, 8'h60);
        chk("R7 data code gone", iir_val, 8'h01);

        // R8 modem status read
        ier = 4'h8; tick();
        chk("R8 modem reported", iir_val, 8'h00);
        rd_acc(2); tick();
        chk("R8 deltas cleared", {4'h0, modem_delta}, 8'h00);
        chk("R8 modem code gone", iir_val, 8'h01);

        // R10 identification read while another code is reported
        ier = 4'h6; pulse_err(3'b010); tick();
        chk("R10 line reported above transmit-empty", iir_val, 8'h06);
        rd_acc(3); rd_acc(0); tick();
        chk("R10 transmit-empty still pending", iir_val, 8'h02);
        // R10 identification read while transmit-empty is reported
        rd_acc(3); tick();
        chk("R10 transmit-empty cleared by identification read", iir_val, 8'h01);
        chk("R10 lsr holding-empty bits kept", lsr_val, 8'h60);

        // R9 holding write and re-arm
        pulse_empty(); tick();
        chk("R9 re-armed by empty pulse", iir_val, 8'h02);
        thr_write(); tick();
        chk("R9 write clears code", iir_val, 8'h01);
        chk("R9 write clears lsr bits 5 and 6", lsr_val, 8'h00);
        pulse_empty(); tick();
        chk("R9 empty pulse sets lsr again", lsr_val, 8'h60);
        chk("R9 empty pulse re-arms irq", {7'b0, irq}, 8'h01);

        // R11 set wins against a coinciding clear
        ier = 4'h0;
        rx_byte_set = 1'b1; host_rd = 1'b1; sel_rbr = 1'b1; tick();
        rx_byte_set = 1'b0; host_rd = 1'b0; sel_rbr = 1'b0;
        chk("R11 data ready survives coinciding read", {7'b0, lsr_val[0]}, 8'h01);
        modem_delta_set = 4'h4; host_rd = 1'b1; sel_msr = 1'b1; tick();
        modem_delta_set = 4'h0; host_rd = 1'b0; sel_msr = 1'b0;
        chk("R11 delta survives coinciding read", {4'h0, modem_delta}, 8'h04);
        tx_empty_set = 1'b1; host_wr = 1'b1; sel_thr = 1'b1; tick();
        tx_empty_set = 1'b0; host_wr = 1'b0; sel_thr = 1'b0;
        chk("R11 holding-empty survives coinciding write", {7'b0, lsr_val[5]}, 8'h01);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule